// File: doc/BRIEF.md
# Coprocessor Context Frame Save/Restore Unit

This block carries out the two context-switch instructions of a floating-point coprocessor. A save stores a fixed idle-state frame to memory. The frame is seven 32-bit words (28 bytes), written one word at a time through a simple memory port with a ready handshake. A restore fetches only the first word of a frame and classifies it:

- A zero word is a null frame.
- The idle marker is accepted. When the addressing mode is postincrement, the address register is advanced past the frame.
- Any other value is reported as an unimplemented frame.

A request arrives as a one-cycle start strobe carrying the operation, the already computed base address and the instruction's addressing-mode and register fields. The unit checks that the addressing mode is one that refers to memory. It then runs a small sequencer, and on completion it pulses `done_o` for one cycle. In that same cycle it can also pulse an error flag or an address-register write. Start strobes that arrive while an operation is in flight are dropped.

Top module: `ctx_frame_unit`

## Requirements
- R1: A save with an accepted mode writes exactly seven words, at base+0, +4, +8, +12, +16, +20 and +24, in increasing address order. `mem_we_o` is 1 on each beat. Address and data stay stable while `mem_ready_i` is low. A save takes 7 beats of (wait cycles + 1) plus one accept cycle before `done_o`.
- R2: The saved words are 0x1F180000 at offset 0, 0x70000000 at offset 24, and zero at the five offsets in between.
- R3: A restore with an accepted mode issues exactly one read (`mem_we_o` = 0), at the base address, and no write.
- R4: A restore that reads 0x00000000 completes with `err_o` = 0 and `areg_we_o` = 0.
- R5: A restore that reads 0x1F180000 completes without error. When `ea_mode_i` = 3 (postincrement), `areg_we_o` pulses with `done_o`, with `areg_idx_o` = `ea_reg_i` and `areg_val_o` = base+28. For any other accepted mode, no register write occurs.
- R6: A restore that reads any other nonzero word completes with `err_o` = 1 and no register write.
- R7: Accepted modes are `ea_mode_i` 2 to 6 with any `ea_reg_i`, and `ea_mode_i` 7 with `ea_reg_i` 0 to 4. Any other combination completes one cycle after start with `err_o` = 1 and makes no memory request, for either operation.
- R8: `done_o` is high for exactly one cycle per accepted start. `err_o` and `areg_we_o` are only ever high together with `done_o`. A restore completes (wait cycles + 2) cycles after start.
- R9: A start strobe (`start_i` = 1) arriving while an operation is in flight is ignored. It changes neither the addresses used nor the number of accesses.
- R10: After reset, `mem_req_o`, `done_o`, `err_o` and `areg_we_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe, taken only when idle |
| op_restore_i | input | 1 | 1 = restore, 0 = save |
| base_addr_i | input | ADDR_W | Frame base address |
| ea_mode_i | input | 3 | Addressing-mode code of the instruction |
| ea_reg_i | input | 3 | Register field of the instruction |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Unimplemented frame or rejected mode, with done |
| areg_we_o | output | 1 | Address-register update strobe, with done |
| areg_idx_o | output | 3 | Address register to update |
| areg_val_o | output | ADDR_W | New address-register value |

## Verification
The mode check is swept across all 64 combinations of mode and register field, for both saves and restores. This separates accepted modes from rejected ones by whether any memory traffic appears at all. Saves are run with memory wait states of 0 to 2 cycles. The complete frame contents, the address order and the completion latency are checked, which tells a correct per-beat handshake apart from one that skips or repeats beats. Restores are fed four first words for every mode: zero, the idle marker, the tail marker and a marker off by one bit. This distinguishes the null, idle and unrecognised paths, and shows that a register update occurs only for postincrement. One further run pulses start repeatedly during a save, to show that the pulses leave the frame and the access counts unchanged.

// File: rtl/ctx_frame_pkg.sv
package ctx_frame_pkg;

    localparam int          WORD_W      = 32;
    localparam logic [31:0] HEAD_WORD   = 32'h1F18_0000;
    localparam logic [31:0] TAIL_WORD   = 32'h7000_0000;
    localparam logic [2:0]  MODE_POSTINC = 3'd3;
    localparam logic [2:0]  MODE_EXT     = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_LOAD = 2'd2
    } cfu_state_t;

    typedef struct packed {
        logic       restore;
        logic [2:0] mode;
        logic [2:0] areg;
    } cfu_req_t;

    // Memory-referencing addressing modes only.
    function automatic logic mode_accepted(input logic [2:0] mode, input logic [2:0] rfield);
        if (mode >= 3'd2 && mode <= 3'd6) return 1'b1;
        if (mode == MODE_EXT && rfield <= 3'd4) return 1'b1;
        return 1'b0;
    endfunction

    // Idle-frame content: marker head, marker tail, zeros between.
    function automatic logic [31:0] frame_word(input int beat, input int last);
        if (beat == 0)    return HEAD_WORD;
        if (beat == last) return TAIL_WORD;
        return '0;
    endfunction

endpackage

// File: rtl/ctx_mode_check.sv
module ctx_mode_check
    import ctx_frame_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic [2:0] reg_i,
    output logic       ok_o
);
    assign ok_o = mode_accepted(mode_i, reg_i);
endmodule

// File: rtl/ctx_frame_rom.sv
module ctx_frame_rom
    import ctx_frame_pkg::*;
#(
    parameter int FRAME_WORDS = 7,
    parameter int BEAT_W      = 3
) (
    input  logic [BEAT_W-1:0] beat_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o = frame_word(int'(beat_i), FRAME_WORDS - 1);
    end
endmodule

// File: rtl/ctx_frame_unit.sv
module ctx_frame_unit
    import ctx_frame_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int FRAME_WORDS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              op_restore_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [2:0]        ea_mode_i,
    input  logic [2:0]        ea_reg_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              done_o,
    output logic              err_o,
    output logic              areg_we_o,
    output logic [2:0]        areg_idx_o,
    output logic [ADDR_W-1:0] areg_val_o
);
    localparam int BEAT_W      = $clog2(FRAME_WORDS);
    localparam int FRAME_BYTES = FRAME_WORDS * (WORD_W / 8);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(FRAME_WORDS - 1);

    cfu_state_t          state_q;
    cfu_req_t            req_q;
    logic [ADDR_W-1:0]   base_q;
    logic [BEAT_W-1:0]   beat_q;
    logic                done_q, err_q, awe_q;
    logic [ADDR_W-1:0]   aval_q;
    logic                mode_ok;
    logic [WORD_W-1:0]   rom_word;

    ctx_mode_check u_mode (
        .mode_i (ea_mode_i),
        .reg_i  (ea_reg_i),
        .ok_o   (mode_ok)
    );

    ctx_frame_rom #(.FRAME_WORDS(FRAME_WORDS), .BEAT_W(BEAT_W)) u_rom (
        .beat_i (beat_q),
        .word_o (rom_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            base_q  <= '0;
            beat_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            awe_q   <= 1'b0;
            aval_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            awe_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q  <= '{restore: op_restore_i, mode: ea_mode_i, areg: ea_reg_i};
                        base_q <= base_addr_i;
                        beat_q <= '0;
                        if (!mode_ok) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else if (op_restore_i) begin
                            state_q <= ST_LOAD;
                        end else begin
                            state_q <= ST_SAVE;
                        end
                    end
                end
                ST_SAVE: begin
                    if (mem_ready_i) begin
                        if (beat_q == LAST_BEAT) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (mem_ready_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        if (mem_rdata_i == HEAD_WORD) begin
                            if (req_q.mode == MODE_POSTINC) begin
                                awe_q  <= 1'b1;
                                aval_q <= base_q + ADDR_W'(FRAME_BYTES);
                            end
                        end else if (mem_rdata_i != '0) begin
                            err_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req_o   = (state_q != ST_IDLE);
    assign mem_we_o    = (state_q == ST_SAVE);
    assign mem_addr_o  = base_q + ADDR_W'({beat_q, 2'b00});
    assign mem_wdata_o = (state_q == ST_SAVE) ? rom_word : '0;
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign areg_we_o   = awe_q;
    assign areg_idx_o  = req_q.areg;
    assign areg_val_o  = aval_q;

    // R1: request held stable until accepted
    a_r1_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

    // R1: consecutive save beats step by one word
    a_r1_step_word: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_we_o && mem_ready_i && beat_q != LAST_BEAT
        |=> mem_we_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(4));

    // R3: a restore makes a single access and then releases the port
    a_r3_single_read: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_we_o && mem_ready_i |=> !mem_req_o);

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> !done_o);

    // R8: error only together with done
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    // R5: register update only on a clean completion
    a_r5_awe_clean: assert property (@(posedge clk) disable iff (rst)
        areg_we_o |-> done_o && !err_o);

    // R9: a start while busy leaves the captured base untouched
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && start_i |=> $stable(base_q));

endmodule

// File: tb/tb_ctx_frame_unit.sv
`timescale 1ns/1ps
module tb_ctx_frame_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        op_restore_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [2:0]  ea_mode_i = '0;
    logic [2:0]  ea_reg_i = '0;
    logic        mem_req_o, mem_we_o, mem_ready_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        done_o, err_o, areg_we_o;
    logic [2:0]  areg_idx_o;
    logic [31:0] areg_val_o;

    always #2.5 clk = ~clk;

    ctx_frame_unit dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_restore_i(op_restore_i),
        .base_addr_i(base_addr_i), .ea_mode_i(ea_mode_i), .ea_reg_i(ea_reg_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
        .done_o(done_o), .err_o(err_o), .areg_we_o(areg_we_o),
        .areg_idx_o(areg_idx_o), .areg_val_o(areg_val_o)
    );

    // memory model
    logic [31:0] mem [0:63];
    logic [31:0] wr_log [0:15];
    int          wr_cnt, rd_cnt, wcnt, lat_sel;
    logic        clr;
    logic [5:0]  pre_idx;
    logic [31:0] pre_val;

    assign mem_ready_i = mem_req_o && (wcnt >= lat_sel);
    assign mem_rdata_i = mem[mem_addr_o[7:2]];

    always @(posedge clk) begin
        if (rst || !mem_req_o || mem_ready_i) wcnt <= 0;
        else wcnt <= wcnt + 1;
        if (clr) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hDEAD_BEEF;
            mem[pre_idx] <= pre_val;
            wr_cnt <= 0;
            rd_cnt <= 0;
        end else if (mem_req_o && mem_ready_i) begin
            if (mem_we_o) begin
                mem[mem_addr_o[7:2]] <= mem_wdata_o;
                if (wr_cnt < 16) wr_log[wr_cnt] <= mem_addr_o;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    int errors = 0, checks = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic prep(input logic [31:0] base, input logic [31:0] first);
        @(negedge clk);
        pre_idx = base[7:2];
        pre_val = first;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic run_op(input bit rd, input logic [31:0] base, input logic [2:0] m,
                          input logic [2:0] r, input int lat, output int cyc);
        lat_sel = lat;
        op_restore_i = rd;
        base_addr_i = base;
        ea_mode_i = m;
        ea_reg_i = r;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic bit exp_ok(input logic [2:0] m, input logic [2:0] r);
        return (m >= 2 && m <= 6) || (m == 7 && r <= 4);
    endfunction

    int cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=0x%08h expected=0x%08h", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [31:0] words [0:3];
        clr = 1'b0;
        pre_idx = '0;
        pre_val = '0;
        lat_sel = 0;
        words[0] = 32'h0000_0000;
        words[1] = 32'h1F18_0000;
        words[2] = 32'h7000_0000;
        words[3] = 32'h1F18_0001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!mem_req_o && !done_o && !err_o && !areg_we_o, "R10 reset outputs",
              {28'd0, mem_req_o, done_o, err_o, areg_we_o}, 32'd0);

        // Save sweep over every mode/register field combination
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 8; r++) begin
                int lat;
                logic [31:0] base;
                bit ok;
                lat = (m + r) % 3;
                base = 32'h40 + 32'(((m * 8 + r) % 4) * 32);
                ok = exp_ok(3'(m), 3'(r));
                prep(base, 32'hDEAD_BEEF);
                run_op(1'b0, base, 3'(m), 3'(r), lat, cyc);
                if (ok) begin
                    check(!err_o && done_o, "R7 accepted save no error", {31'd0, err_o}, 32'd0);
                    check(cyc == 1 + 7 * (lat + 1), "R1 save latency", 32'(cyc), 32'(1 + 7 * (lat + 1)));
                    check(wr_cnt == 7 && rd_cnt == 0, "R1 save write count", 32'(wr_cnt), 32'd7);
                    for (int i = 0; i < 7; i++) begin
                        logic [31:0] e;
                        e = (i == 0) ? 32'h1F18_0000 : (i == 6) ? 32'h7000_0000 : 32'h0;
                        check(wr_log[i] == base + 32'(4 * i), "R1 save address order", wr_log[i], base + 32'(4 * i));
                        check(mem[base[7:2] + 6'(i)] == e, "R2 frame word", mem[base[7:2] + 6'(i)], e);
                    end
                end else begin
                    check(err_o && done_o, "R7 rejected save error", {30'd0, done_o, err_o}, 32'd3);
                    check(cyc == 1, "R7 rejected latency", 32'(cyc), 32'd1);
                    check(wr_cnt == 0 && rd_cnt == 0, "R7 rejected no access", 32'(wr_cnt + rd_cnt), 32'd0);
                end
                check(!areg_we_o, "R5 save no register write", {31'd0, areg_we_o}, 32'd0);
                @(negedge clk);
                check(!done_o && !err_o, "R8 done single cycle", {30'd0, done_o, err_o}, 32'd0);
            end
        end

        // Restore sweep: every mode/register field combination against four first words
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 8; r++) begin
                for (int w = 0; w < 4; w++) begin
                    int lat;
                    logic [31:0] base;
                    bit ok, e_err, e_awe;
                    lat = (m + w) % 3;
                    base = 32'h20 + 32'(((r + w) % 4) * 48);
                    ok = exp_ok(3'(m), 3'(r));
                    prep(base, words[w]);
                    run_op(1'b1, base, 3'(m), 3'(r), lat, cyc);
                    if (ok) begin
                        e_err = (w >= 2);
                        e_awe = (w == 1) && (m == 3);
                        check(cyc == lat + 2, "R8 restore latency", 32'(cyc), 32'(lat + 2));
                        check(rd_cnt == 1 && wr_cnt == 0, "R3 one read no write", 32'(rd_cnt * 16 + wr_cnt), 32'h10);
                        if (w == 0)
                            check(!err_o && !areg_we_o, "R4 null frame", {30'd0, err_o, areg_we_o}, 32'd0);
                        else if (w == 1)
                            check(!err_o && areg_we_o == e_awe, "R5 idle frame",
                                  {30'd0, err_o, areg_we_o}, {30'd0, 1'b0, e_awe});
                        else
                            check(err_o && !areg_we_o, "R6 unknown frame", {30'd0, err_o, areg_we_o}, 32'd2);
                        if (e_awe) begin
                            check(areg_val_o == base + 32'd28, "R5 postinc value", areg_val_o, base + 32'd28);
                            check(areg_idx_o == 3'(r), "R5 register index", {29'd0, areg_idx_o}, 32'(r));
                        end
                        check(err_o == e_err, "R6 error flag", {31'd0, err_o}, {31'd0, e_err});
                    end else begin
                        check(err_o && done_o && cyc == 1, "R7 rejected restore", {31'd0, err_o}, 32'd1);
                        check(rd_cnt == 0 && wr_cnt == 0 && !areg_we_o, "R7 restore no access",
                              32'(rd_cnt + wr_cnt), 32'd0);
                    end
                    @(negedge clk);
                    check(!done_o && !areg_we_o, "R8 done single cycle", {30'd0, done_o, areg_we_o}, 32'd0);
                end
            end
        end

        // R9: start pulses while busy are dropped
        prep(32'h00, 32'hDEAD_BEEF);
        lat_sel = 1;
        op_restore_i = 1'b0;
        base_addr_i = 32'h00;
        ea_mode_i = 3'd2;
        ea_reg_i = 3'd0;
        start_i = 1'b1;
        @(negedge clk);
        op_restore_i = 1'b1;
        base_addr_i = 32'h80;
        ea_mode_i = 3'd3;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        cyc = 4;
        while (!done_o && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 15, "R9 busy start latency", 32'(cyc), 32'd15);
        check(wr_cnt == 7 && rd_cnt == 0, "R9 busy start access count", 32'(wr_cnt * 16 + rd_cnt), 32'h70);
        check(wr_log[6] == 32'h18 && mem[0] == 32'h1F18_0000, "R9 busy start base", wr_log[6], 32'h18);
        check(mem[32] == 32'hDEAD_BEEF, "R9 other base untouched", mem[32], 32'hDEAD_BEEF);
        @(negedge clk);
        check(!done_o && !mem_req_o, "R9 no second operation", {30'd0, done_o, mem_req_o}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule